// File: doc/BRIEF.md
# Segmented Dual-Bus Register Datapath

This block is a register-transfer datapath with two global busses, A and B. The busses cross three adjacent 16-bit sections. Section 0 is the data section, section 1 is the low address half and section 2 is the high address half. Each section holds four registers, and each register has two read ports, so it can drive bus A, bus B or both in the same cycle. Every segment can also take a word from an external injection port. Register k of section 1 and register k of section 2 together form one 32-bit address pair, with the low half in section 1.

At each of the two section boundaries, each bus has a direction-controlled coupler. An open coupler isolates the two segments on either side, so three sections times two busses give up to six independent transfers per cycle. A closed coupler carries the value toward the higher or the lower section index. A source can therefore load a register in the next section, or in the section beyond it when both couplers on that bus point the same way. The whole design is built from multiplexers.

Each cycle the block takes a set of transfer commands and loads registers on the rising edge. It detects illegal driver configurations; in such a cycle no register is written, and a registered error flag rises on the next cycle.

Top module: `dp_segbus`

## Requirements
- R1: A synchronous active-high reset clears every register to zero and clears `err_o`.
- R2: A segment (section s, bus b, index s*2+b) with `src_en_i` set carries the register of section s selected by its 2-bit field in `src_idx_i`. With `ext_en_i` set instead, it carries the matching 16-bit slice of `ext_data_i`.
- R3: One register may drive both bus segments of its section in the same cycle, and each bus then shows its value.
- R4: With bit s*4+r of `wr_en_i` set, register r of section s loads on the rising edge from its section's bus A segment when the matching `wr_bus_i` bit is 0, and from bus B when it is 1.
- R5: When all couplers are open, the six segments are independent, and six writes sourced from six different segments all complete in one cycle.
- R6: Coupler mode (2 bits at `cpl_mode_i[(k*2+b)*2 +: 2]`, boundary k between sections k and k+1) 01 passes the value toward the higher section index, and 10 passes it toward the lower index.
- R7: With both couplers of a bus in the same passing direction, a value driven in an end section reaches the other end section.
- R8: Coupler mode 11 behaves exactly as open.
- R9: A segment that nothing reaches reads zero, a register written from it becomes zero, and this is not an error.
- R10: A cycle is illegal when a segment has both `src_en_i` and `ext_en_i` set, when a coupler passes into a segment that has its own local driver, or when two driven values reach the same segment from both sides. `err_o` is 1 in the cycle after an illegal cycle and 0 after a legal one.
- R11: In an illegal cycle no register in any section is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en_i | input | 6 | Per segment: a register drives the segment |
| src_idx_i | input | 12 | Per segment: 2-bit register index |
| ext_en_i | input | 6 | Per segment: the external word drives the segment |
| ext_data_i | input | 96 | Per segment: 16-bit external word |
| cpl_mode_i | input | 8 | Per boundary and bus: 2-bit coupler mode |
| wr_en_i | input | 12 | Per register: write enable |
| wr_bus_i | input | 12 | Per register: 0 loads from bus A, 1 from bus B |
| seg_o | output | 96 | Current value of every bus segment |
| err_o | output | 1 | Registered illegal-configuration flag |

## Verification
A corrupted register stays hidden until a later cycle drives it onto a segment. From that cycle on, `seg_o` shows a wrong word, so the bench reads back all registers after each scenario. A wrong coupler decision shows at `seg_o` in the same cycle. A wrong legality decision shows one cycle later at `err_o`, and it also leaves registers written or unwritten against expectation, which the next read-back exposes. A reference model recomputes every segment and the flag on every clock.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int NSEC = 3;
  localparam int NBUS = 2;
  localparam int NCPL = NSEC - 1;

  typedef enum logic [1:0] {
    CPL_OPEN = 2'b00,
    CPL_L2R  = 2'b01,
    CPL_R2L  = 2'b10,
    CPL_RSV  = 2'b11
  } cpl_mode_e;
endpackage

// File: rtl/dp_regbank.sv
module dp_regbank
  import dp_pkg::*;
#(
  parameter int W    = 16,
  parameter int NREG = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hold_i,
  input  logic [NREG-1:0]           wr_en_i,
  input  logic [NREG-1:0]           wr_bus_i,
  input  logic [NBUS-1:0][W-1:0]    seg_i,
  input  logic [NBUS-1:0][IW-1:0]   rd_idx_i,
  output logic [NBUS-1:0][W-1:0]    rd_o
);
  logic [W-1:0] q [NREG];

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (rst)
        q[r] <= '0;
      else if (wr_en_i[r] && !hold_i)
        q[r] <= seg_i[wr_bus_i[r]];
    end
  end

  for (genvar b = 0; b < NBUS; b++) begin : g_rd
    assign rd_o[b] = q[rd_idx_i[b]];
  end

  for (genvar r = 0; r < NREG; r++) begin : g_chk
    // R4
    wr_commit_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en_i[r] && !hold_i) |=> q[r] == $past(seg_i[wr_bus_i[r]]));
    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      hold_i |=> $stable(q[r]));
  end
endmodule

// File: rtl/dp_busseg.sv
module dp_busseg
  import dp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSEC-1:0]         loc_en_i,
  input  logic [NSEC-1:0]         ext_en_i,
  input  logic [NSEC-1:0][W-1:0]  loc_val_i,
  input  logic [NSEC-1:0][W-1:0]  ext_val_i,
  input  logic [NCPL-1:0][1:0]    mode_i,
  output logic [NSEC-1:0][W-1:0]  seg_o,
  output logic                    err_o
);
  logic [NSEC-1:0]        drv, pt_l, pt_r, in_l, in_r;
  logic [NSEC-1:0][W-1:0] dval, v_l, v_r;

  always_comb begin
    drv  = loc_en_i | ext_en_i;
    for (int s = 0; s < NSEC; s++)
      dval[s] = ext_en_i[s] ? ext_val_i[s] : loc_val_i[s];

    pt_l = '0; in_l = '0; v_l = '0;
    for (int s = 1; s < NSEC; s++) begin
      pt_l[s] = (cpl_mode_e'(mode_i[s-1]) == CPL_L2R);
      in_l[s] = pt_l[s] && (drv[s-1] || in_l[s-1]);
      v_l[s]  = drv[s-1] ? dval[s-1] : v_l[s-1];
    end

    pt_r = '0; in_r = '0; v_r = '0;
    for (int s = NSEC - 2; s >= 0; s--) begin
      pt_r[s] = (cpl_mode_e'(mode_i[s]) == CPL_R2L);
      in_r[s] = pt_r[s] && (drv[s+1] || in_r[s+1]);
      v_r[s]  = drv[s+1] ? dval[s+1] : v_r[s+1];
    end

    for (int s = 0; s < NSEC; s++) begin
      if (drv[s])       seg_o[s] = dval[s];
      else if (in_l[s]) seg_o[s] = v_l[s];
      else if (in_r[s]) seg_o[s] = v_r[s];
      else              seg_o[s] = '0;
    end

    err_o = |(loc_en_i & ext_en_i) | |(pt_l & drv) | |(pt_r & drv)
          | |(in_l & in_r);
  end

  for (genvar s = 0; s < NSEC; s++) begin : g_chk
    // R10
    one_source_chk: assert property (@(posedge clk) disable iff (rst)
      !err_o |-> $onehot0({drv[s], in_l[s], in_r[s]}));
    // R9
    isolated_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!drv[s] && !in_l[s] && !in_r[s]) |-> seg_o[s] == '0);
  end
endmodule

// File: rtl/dp_segbus.sv
module dp_segbus
  import dp_pkg::*;
#(
  parameter int W    = 16,
  parameter int NREG = 4,
  localparam int IW  = $clog2(NREG),
  localparam int NSEG = NSEC * NBUS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NSEG-1:0]          src_en_i,
  input  logic [NSEG*IW-1:0]       src_idx_i,
  input  logic [NSEG-1:0]          ext_en_i,
  input  logic [NSEG*W-1:0]        ext_data_i,
  input  logic [NCPL*NBUS*2-1:0]   cpl_mode_i,
  input  logic [NSEC*NREG-1:0]     wr_en_i,
  input  logic [NSEC*NREG-1:0]     wr_bus_i,
  output logic [NSEG*W-1:0]        seg_o,
  output logic                     err_o
);
  logic [NBUS-1:0][W-1:0]   sec_rd  [NSEC];
  logic [NBUS-1:0][W-1:0]   sec_seg [NSEC];
  logic [NBUS-1:0][IW-1:0]  sec_idx [NSEC];
  logic [NSEC-1:0][W-1:0]   bus_rd  [NBUS];
  logic [NSEC-1:0][W-1:0]   bus_ext [NBUS];
  logic [NSEC-1:0][W-1:0]   bus_seg [NBUS];
  logic [NSEC-1:0]          bus_loc [NBUS];
  logic [NSEC-1:0]          bus_xen [NBUS];
  logic [NCPL-1:0][1:0]     bus_mode [NBUS];
  logic [NBUS-1:0]          bus_err;
  logic                     err_now;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    for (genvar b = 0; b < NBUS; b++) begin : g_bus
      assign sec_idx[s][b] = src_idx_i[(s*NBUS+b)*IW +: IW];
      assign sec_seg[s][b] = bus_seg[b][s];
      assign bus_rd[b][s]  = sec_rd[s][b];
      assign bus_ext[b][s] = ext_data_i[(s*NBUS+b)*W +: W];
      assign bus_loc[b][s] = src_en_i[s*NBUS+b];
      assign bus_xen[b][s] = ext_en_i[s*NBUS+b];
      assign seg_o[(s*NBUS+b)*W +: W] = bus_seg[b][s];
    end

    dp_regbank #(.W(W), .NREG(NREG)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .hold_i   (err_now),
      .wr_en_i  (wr_en_i[s*NREG +: NREG]),
      .wr_bus_i (wr_bus_i[s*NREG +: NREG]),
      .seg_i    (sec_seg[s]),
      .rd_idx_i (sec_idx[s]),
      .rd_o     (sec_rd[s])
    );
  end

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    for (genvar k = 0; k < NCPL; k++) begin : g_cpl
      assign bus_mode[b][k] = cpl_mode_i[(k*NBUS+b)*2 +: 2];
    end

    dp_busseg #(.W(W)) u_seg (
      .clk       (clk),
      .rst       (rst),
      .loc_en_i  (bus_loc[b]),
      .ext_en_i  (bus_xen[b]),
      .loc_val_i (bus_rd[b]),
      .ext_val_i (bus_ext[b]),
      .mode_i    (bus_mode[b]),
      .seg_o     (bus_seg[b]),
      .err_o     (bus_err[b])
    );
  end

  assign err_now = |bus_err;

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= err_now;
  end

  // R10
  err_flag_chk: assert property (@(posedge clk) disable iff (rst)
    err_now |=> err_o);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !err_o);
endmodule

// File: tb/sim_dp_segbus.sv
module sim_dp_segbus;
  localparam int W = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  src_en_i = '0;
  logic [11:0] src_idx_i = '0;
  logic [5:0]  ext_en_i = '0;
  logic [95:0] ext_data_i = '0;
  logic [7:0]  cpl_mode_i = '0;
  logic [11:0] wr_en_i = '0;
  logic [11:0] wr_bus_i = '0;
  logic [95:0] seg_o;
  logic        err_o;

  int nchk = 0;
  int nerr = 0;
  bit started = 0;

  logic [W-1:0] mreg [3][4];
  logic [W-1:0] mseg [3][2];
  bit merr, merr_q;

  always #2 clk = ~clk;

  dp_segbus u0 (
    .clk(clk), .rst(rst), .src_en_i(src_en_i), .src_idx_i(src_idx_i),
    .ext_en_i(ext_en_i), .ext_data_i(ext_data_i), .cpl_mode_i(cpl_mode_i),
    .wr_en_i(wr_en_i), .wr_bus_i(wr_bus_i), .seg_o(seg_o), .err_o(err_o)
  );

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp, string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_eval();
    bit loc [3];
    logic [W-1:0] val [3];
    merr = 0;
    for (int b = 0; b < 2; b++) begin
      for (int s = 0; s < 3; s++) begin
        loc[s] = src_en_i[s*2+b] || ext_en_i[s*2+b];
        if (src_en_i[s*2+b] && ext_en_i[s*2+b]) merr = 1;
        val[s] = ext_en_i[s*2+b] ? ext_data_i[(s*2+b)*W +: W]
                                 : mreg[s][src_idx_i[(s*2+b)*2 +: 2]];
      end
      for (int k = 0; k < 2; k++) begin
        if (cpl_mode_i[(k*2+b)*2 +: 2] == 2'b01 && loc[k+1]) merr = 1;
        if (cpl_mode_i[(k*2+b)*2 +: 2] == 2'b10 && loc[k])   merr = 1;
      end
      for (int s = 0; s < 3; s++) begin
        int cnt = 0;
        mseg[s][b] = '0;
        for (int t = 0; t < 3; t++) begin
          bit ok = loc[t];
          if (t < s) for (int k = t; k < s; k++) ok &= (cpl_mode_i[(k*2+b)*2 +: 2] == 2'b01);
          if (t > s) for (int k = s; k < t; k++) ok &= (cpl_mode_i[(k*2+b)*2 +: 2] == 2'b10);
          if (ok) begin cnt++; mseg[s][b] = val[t]; end
        end
        if (cnt > 1) merr = 1;
      end
    end
  endtask

  task automatic step(string tag);
    #1;
    model_eval();
    if (started) begin
      if (!rst && !merr)
        for (int s = 0; s < 3; s++)
          for (int b = 0; b < 2; b++)
            chk(tag, seg_o[(s*2+b)*W +: W], mseg[s][b], $sformatf("seg s%0d b%0d", s, b));
      chk(tag, {15'd0, err_o}, {15'd0, merr_q}, "err_o");
    end
    @(posedge clk);
    started = 1;
    if (rst) begin
      merr_q = 0;
      for (int s = 0; s < 3; s++) for (int r = 0; r < 4; r++) mreg[s][r] = '0;
    end else begin
      merr_q = merr;
      if (!merr)
        for (int s = 0; s < 3; s++)
          for (int r = 0; r < 4; r++)
            if (wr_en_i[s*4+r]) mreg[s][r] = mseg[s][wr_bus_i[s*4+r]];
    end
    @(negedge clk);
  endtask

  task automatic clr();
    src_en_i = '0; src_idx_i = '0; ext_en_i = '0; ext_data_i = '0;
    cpl_mode_i = '0; wr_en_i = '0; wr_bus_i = '0;
  endtask
  task automatic src(int s, int b, int idx);
    src_en_i[s*2+b] = 1'b1; src_idx_i[(s*2+b)*2 +: 2] = 2'(idx);
  endtask
  task automatic ext(int s, int b, logic [W-1:0] d);
    ext_en_i[s*2+b] = 1'b1; ext_data_i[(s*2+b)*W +: W] = d;
  endtask
  task automatic cpl(int k, int b, logic [1:0] m);
    cpl_mode_i[(k*2+b)*2 +: 2] = m;
  endtask
  task automatic wr(int s, int r, int b);
    wr_en_i[s*4+r] = 1'b1; wr_bus_i[s*4+r] = 1'(b);
  endtask
  task automatic readback(string tag);
    for (int i = 0; i < 4; i++) begin
      clr();
      for (int g = 0; g < 6; g++) src(g / 2, g % 2, i);
      step(tag);
    end
    clr();
  endtask

  initial begin
    #800000;
    nerr++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int s = 0; s < 3; s++) for (int r = 0; r < 4; r++) mreg[s][r] = 'x;
    merr_q = 0;
    @(negedge clk);
    clr(); rst = 1;
    step("R1"); step("R1");
    rst = 0;
    readback("R1");

    // R5: six injected words, six writes in one cycle
    clr();
    ext(0,0,16'h1111); ext(0,1,16'h2222); ext(1,0,16'h3333);
    ext(1,1,16'h4444); ext(2,0,16'h5555); ext(2,1,16'h6666);
    wr(0,0,0); wr(0,1,1); wr(1,0,0); wr(1,1,1); wr(2,0,0); wr(2,1,1);
    step("R5");
    readback("R5");

    // R2 / R4: register source, load into another register via bus B
    clr(); src(1,1,1); wr(1,2,1); src(2,0,0); wr(2,3,0); step("R2");
    clr(); ext(0,1,16'hA5A5); wr(0,2,1); ext(0,0,16'h0F0F); wr(0,3,0); step("R4");
    readback("R4");

    // R3: one register on both busses
    clr(); src(0,0,2); src(0,1,2); wr(0,1,0); wr(0,0,1); step("R3");
    readback("R3");

    // R6: toward higher index on bus A, toward lower index on bus B
    clr(); src(0,0,0); cpl(0,0,2'b01); wr(1,3,0); step("R6");
    clr(); src(2,1,1); cpl(1,1,2'b10); wr(1,2,1); step("R6");
    readback("R6");

    // R7: end to end in both directions
    clr(); src(0,0,3); cpl(0,0,2'b01); cpl(1,0,2'b01); wr(2,2,0); step("R7");
    clr(); src(2,1,0); cpl(0,1,2'b10); cpl(1,1,2'b10); wr(0,0,1); wr(1,1,1); step("R7");
    readback("R7");

    // R8: reserved mode isolates; R9: undriven reads zero
    clr(); ext(0,0,16'hBEEF); cpl(0,0,2'b11); wr(1,0,0); step("R8");
    clr(); ext(2,1,16'hCAFE); cpl(1,1,2'b11); wr(1,1,1); step("R8");
    readback("R8");
    clr(); wr(2,0,0); wr(2,1,1); step("R9");
    readback("R9");

    // R10 / R11: illegal cycles with writes requested
    clr(); src(0,0,1); ext(0,0,16'h7777); wr(0,0,0); wr(1,0,1); step("R10");
    clr(); ext(0,0,16'h1234); ext(1,0,16'h4321); cpl(0,0,2'b01); wr(1,1,0); step("R10");
    clr(); ext(0,1,16'h1357); ext(2,1,16'h2468); cpl(0,1,2'b01); cpl(1,1,2'b10);
    wr(1,3,1); wr(0,1,0); step("R11");
    clr(); ext(1,0,16'h9999); cpl(0,0,2'b10); ext(0,0,16'h8888); wr(2,2,0); step("R11");
    clr(); step("R10");
    readback("R11");

    // mixed patterns
    for (int n = 0; n < 400; n++) begin
      clr();
      src_en_i  = 6'($urandom);
      src_idx_i = 12'($urandom);
      ext_en_i  = 6'($urandom) & 6'($urandom);
      ext_data_i = {$urandom, $urandom, $urandom};
      cpl_mode_i = 8'($urandom) & 8'($urandom);
      wr_en_i   = 12'($urandom);
      wr_bus_i  = 12'($urandom);
      step("Rmix");
    end
    readback("Rmix");

    // R1: reset in mid-run
    clr(); rst = 1; step("R1"); rst = 0;
    readback("R1");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule